// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of an SDRAM read or write burst. A controller pulses a start strobe together with the starting column, a burst-length code, an ordering select (linear or interleaved) and a device-width code. From the following clock on, the block presents one column per cycle, with a valid flag and a last-beat flag. It stops at the end of a finite burst, or when the controller asks it to stop.

Finite bursts of 2, 4 or 8 beats reorder only the low column bits inside the naturally aligned block that holds the starting column. Linear ordering counts upward and wraps inside that block. Interleaved ordering XORs the start offset with the beat number. A page-length burst walks linearly across the whole column field and wraps at its end, and it runs until it is stopped or replaced. Page-length bursts do not support interleaved ordering. When that pairing is requested, the block flags it and uses linear order instead.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, `beat_valid_o`, `beat_last_o` and `mode_err_o` are low, and they stay low until a start is accepted.
- R2: A start strobe sampled at a clock edge makes beat 0 valid in the next cycle, at the starting column. Each later clock advances the burst by exactly one beat.
- R3: `len_i` encoding: 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 7 = page length. Codes 4, 5 and 6 behave as a 1-beat burst.
- R4: In linear order, the low log2(L) bits of beat i equal (start offset + i) mod L. For example, start 2 with L=4 gives 2,3,0,1.
- R5: In interleaved order, the low log2(L) bits of beat i equal start offset XOR i. For example, start 5 with L=8 gives 5,4,7,6,1,0,3,2.
- R6: Within the column field, the column bits above the burst block keep the starting column's value for the whole burst. Output bits at or above the field width are always zero.
- R7: `width_i` encoding sets the column field width: 0 = 10 bits, 1 = 9 bits, 2 or 3 = 8 bits.
- R8: A page-length burst adds one to the column on every beat, wraps from the field's top value to 0, never raises `beat_last_o`, and runs until it is stopped or replaced.
- R9: A page-length start with interleaved order raises `mode_err_o` on every beat of that burst, and the burst uses linear order. `mode_err_o` is low on all other bursts.
- R10: `beat_last_o` is high on the final beat of a finite burst and only there. The burst is not valid on the cycle after it.
- R11: `stop_i` high on a valid beat ends the burst, so the next cycle is not valid. `stop_i` while idle has no effect.
- R12: A start during a running burst abandons it. Beat 0 of the new burst appears in the next cycle. Start has priority over a simultaneous stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst with the fields below |
| start_col_i | input | X8_W | Starting column |
| len_i | input | 3 | Burst length code (R3) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = linear |
| width_i | input | 2 | Device width code (R7) |
| stop_i | input | 1 | Terminate the running burst |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_col_o | output | X8_W | Column of the current beat |
| beat_last_o | output | 1 | Final beat of a finite burst |
| mode_err_o | output | 1 | Unsupported interleaved page burst in progress |

## Verification
The bench goes after block wrap-around at every start offset. A design that masked the wrong bits would spill into the next block or change the upper column bits. It also checks page-length wrap at each field width: a wrong field mask would run past the row end or wrap too early. It checks that an interleaved page request is flagged and ordered linearly, since XOR ordering there would scatter beats. The remaining targets are stop, restart and start-over-stop priority. A design that got these wrong would emit an extra beat, lose the new burst, or let a stop swallow a start.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
   localparam logic [2:0] LEN_PAGE = 3'd7;

   typedef struct packed {
      logic page;  // page-length burst
      logic ilv;   // interleaved order in effect
      logic err;   // interleaved page-length request
   } col_mode_t;
endpackage

// File: rtl/col_mode_decode.sv
module col_mode_decode
   import sdram_col_pkg::*;
#(
   parameter int CW    = 10,
   parameter int X8_W  = 10,
   parameter int X16_W = 9,
   parameter int X32_W = 8
) (
   input  logic [2:0]    len_i,
   input  logic          ilv_i,
   input  logic [1:0]    width_i,
   output logic [CW-1:0] blk_mask_o,
   output logic [CW-1:0] fld_mask_o,
   output col_mode_t     mode_o
);
   int fw;

   always_comb begin
      case (width_i)
         2'd0:    fw = X8_W;
         2'd1:    fw = X16_W;
         default: fw = X32_W;
      endcase
   end

   for (genvar b = 0; b < CW; b++) begin : g_fld
      assign fld_mask_o[b] = (b < fw);
   end

   always_comb begin
      blk_mask_o = '0;
      case (len_i)
         3'd1:     blk_mask_o[0]   = 1'b1;
         3'd2:     blk_mask_o[1:0] = 2'b11;
         3'd3:     blk_mask_o[2:0] = 3'b111;
         LEN_PAGE: blk_mask_o      = fld_mask_o;
         default:  blk_mask_o      = '0;
      endcase
   end

   always_comb begin
      mode_o.page = (len_i == LEN_PAGE);
      mode_o.err  = ilv_i & mode_o.page;
      mode_o.ilv  = ilv_i & ~mode_o.page;
   end
endmodule

// File: rtl/col_beat_gen.sv
module col_beat_gen #(
   parameter int CW = 10
) (
   input  logic [CW-1:0] scol_i,
   input  logic [CW-1:0] cnt_i,
   input  logic [CW-1:0] blk_mask_i,
   input  logic [CW-1:0] fld_mask_i,
   input  logic          ilv_i,
   output logic [CW-1:0] col_o
);
   logic [CW-1:0] inner;

   assign inner = ilv_i ? (scol_i ^ cnt_i) : (scol_i + cnt_i);

   for (genvar b = 0; b < CW; b++) begin : g_bit
      assign col_o[b] = fld_mask_i[b] & (blk_mask_i[b] ? inner[b] : scol_i[b]);
   end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
   import sdram_col_pkg::*;
#(
   parameter int X8_W  = 10,
   parameter int X16_W = 9,
   parameter int X32_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [X8_W-1:0] start_col_i,
   input  logic [2:0]      len_i,
   input  logic            ilv_i,
   input  logic [1:0]      width_i,
   input  logic            stop_i,
   output logic            beat_valid_o,
   output logic [X8_W-1:0] beat_col_o,
   output logic            beat_last_o,
   output logic            mode_err_o
);
   localparam int CW = X8_W;
   localparam logic [CW-1:0] ONE = CW'(1);

   if (X32_W < 3 || X16_W < X32_W || X8_W < X16_W) begin : g_bad_cfg
      $error("sdram_col_seq: field widths must satisfy 3 <= X32_W <= X16_W <= X8_W");
   end

   logic [CW-1:0] blk_d, fld_d;
   col_mode_t     mode_d;

   logic          act_q;
   logic [CW-1:0] cnt_q, scol_q, blk_q, fld_q;
   col_mode_t     mode_q;
   logic          last;

   col_mode_decode #(.CW(CW), .X8_W(X8_W), .X16_W(X16_W), .X32_W(X32_W)) u_dec (
      .len_i      (len_i),
      .ilv_i      (ilv_i),
      .width_i    (width_i),
      .blk_mask_o (blk_d),
      .fld_mask_o (fld_d),
      .mode_o     (mode_d)
   );

   col_beat_gen #(.CW(CW)) u_gen (
      .scol_i     (scol_q),
      .cnt_i      (cnt_q),
      .blk_mask_i (blk_q),
      .fld_mask_i (fld_q),
      .ilv_i      (mode_q.ilv),
      .col_o      (beat_col_o)
   );

   assign last = act_q & ~mode_q.page & (cnt_q == blk_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         cnt_q  <= '0;
         scol_q <= '0;
         blk_q  <= '0;
         fld_q  <= '0;
         mode_q <= '0;
      end else if (start_i) begin
         act_q  <= 1'b1;
         cnt_q  <= '0;
         scol_q <= start_col_i;
         blk_q  <= blk_d;
         fld_q  <= fld_d;
         mode_q <= mode_d;
      end else if (act_q) begin
         if (stop_i || last) act_q <= 1'b0;
         cnt_q <= cnt_q + ONE;
      end
   end

   assign beat_valid_o = act_q;
   assign beat_last_o  = last;
   assign mode_err_o   = act_q & mode_q.err;
endmodule

module sdram_col_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic stop_i,
   input logic beat_valid_o,
   input logic beat_last_o,
   input logic mode_err_o
);
   p_start_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> beat_valid_o);
   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_valid_o && !start_i) |=> !beat_valid_o);
   p_last_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_last_o && !start_i) |=> !beat_valid_o);
   p_stop_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid_o && stop_i && !start_i) |=> !beat_valid_o);
   p_last_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last_o |-> beat_valid_o);
   p_err_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err_o |-> (beat_valid_o && !beat_last_o));
endmodule

bind sdram_col_seq sdram_col_seq_chk u_chk (.*);

// File: tb/sdram_col_seq_test.sv
module sdram_col_seq_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       start_i = 1'b0;
   logic [9:0] start_col_i = '0;
   logic [2:0] len_i = '0;
   logic       ilv_i = 1'b0;
   logic [1:0] width_i = '0;
   logic       stop_i = 1'b0;
   logic       beat_valid_o, beat_last_o, mode_err_o;
   logic [9:0] beat_col_o;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   sdram_col_seq uut (.*);

   function automatic int fwidth(input logic [1:0] w);
      return (w == 2'd0) ? 10 : (w == 2'd1) ? 9 : 8;
   endfunction

   function automatic int blen(input logic [2:0] l);
      case (l)
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         3'd7: return 0;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col(input int col, input logic [2:0] l, input bit ilv,
                                  input logic [1:0] w, input int i);
      int sz, c, L, off, base;
      sz = 1 << fwidth(w);
      c  = col % sz;
      L  = blen(l);
      if (L == 0) return (c + i) % sz;
      off  = c % L;
      base = c - off;
      if (ilv) return base + (off ^ i);
      return base + ((off + i) % L);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic begin_burst(input int col, input logic [2:0] l, input bit ilv, input logic [1:0] w);
      start_col_i = col[9:0];
      len_i = l; ilv_i = ilv; width_i = w; start_i = 1'b1;
      @(posedge clk); @(negedge clk);
      start_i = 1'b0;
   endtask

   // Beats are checked at the negedge following each clock. stop_at < 0: run to the end.
   task automatic run_burst(input string req, input int col, input logic [2:0] l,
                            input bit ilv, input logic [1:0] w, input int stop_at);
      int L;
      bit page;
      L = blen(l);
      page = (L == 0);
      begin_burst(col, l, ilv, w);
      for (int i = 0; i < 4000; i++) begin
         check({req, " valid"}, beat_valid_o, 1);
         check({req, " col"}, beat_col_o, exp_col(col, l, ilv && !page, w, i));
         check({req, " last R10"}, beat_last_o, (!page && i == L - 1));
         check({req, " err R9"}, mode_err_o, (page && ilv));
         if (i == stop_at) begin
            stop_i = 1'b1;
            @(posedge clk); @(negedge clk);
            stop_i = 1'b0;
            break;
         end
         @(posedge clk); @(negedge clk);
         if (!page && i == L - 1) break;
      end
      check({req, " ends R10 R11"}, beat_valid_o, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 valid", beat_valid_o, 0);
      check("R1 last", beat_last_o, 0);
      check("R1 err", mode_err_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle", beat_valid_o, 0);

      // directed corner cases
      run_burst("R4 seq 2/4", 2, 3'd2, 0, 2'd1, -1);
      run_burst("R5 ilv 5/8", 5, 3'd3, 1, 2'd1, -1);
      run_burst("R6 upper bits", 10'h1F6, 3'd3, 0, 2'd0, -1);
      run_burst("R2 len1", 10'h0AB, 3'd0, 0, 2'd0, -1);
      run_burst("R3 reserved len", 10'h033, 3'd5, 1, 2'd0, -1);
      run_burst("R8 page wrap x8", 10'h3FD, 3'd7, 0, 2'd0, 6);
      run_burst("R7 page wrap x32", 10'h3FE, 3'd7, 0, 2'd2, 4);
      run_burst("R7 page wrap x16", 10'h1FF, 3'd7, 0, 2'd1, 3);
      run_burst("R9 ilv page", 10'h0FE, 3'd7, 1, 2'd3, 5);
      run_burst("R11 stop mid", 6, 3'd3, 1, 2'd0, 2);

      // R11: stop while idle has no effect
      stop_i = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R11 idle stop", beat_valid_o, 0);
      // R12: start wins over simultaneous stop
      begin_burst(3, 3'd2, 0, 2'd0);
      stop_i = 1'b0;
      check("R12 start over stop", beat_valid_o, 1);
      check("R12 start col", beat_col_o, 3);
      @(posedge clk); @(negedge clk);
      check("R12 second beat", beat_col_o, 0);
      // R12: restart mid-burst
      begin_burst(9, 3'd3, 1, 2'd0);
      for (int i = 0; i < 8; i++) begin
         check("R12 restart col", beat_col_o, exp_col(9, 3'd3, 1, 2'd0, i));
         check("R12 restart last", beat_last_o, (i == 7));
         @(posedge clk); @(negedge clk);
      end
      check("R12 restart ends", beat_valid_o, 0);

      // constrained random mix
      for (int n = 0; n < 300; n++) begin
         int col, stop_at;
         logic [2:0] l;
         bit ilv;
         logic [1:0] w;
         col = int'($urandom_range(0, 1023));
         case ($urandom_range(0, 5))
            0: l = 3'd0;
            1: l = 3'd1;
            2: l = 3'd2;
            3: l = 3'd3;
            4: l = 3'd7;
            default: l = 3'($urandom_range(4, 6));
         endcase
         ilv = 1'($urandom_range(0, 1));
         w = 2'($urandom_range(0, 3));
         if (l == 3'd7) stop_at = int'($urandom_range(0, 40));
         else if ($urandom_range(0, 3) == 0) stop_at = int'($urandom_range(0, 7));
         else stop_at = -1;
         run_burst("R2 R4 R5 R6 R7 R8 random", col, l, ilv, w, stop_at);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule